// File: doc/BRIEF.md
# Channel-Grouped Tensor Address Walker

This block produces a stream of linear element offsets. Fetching a tensor in the order of these offsets delivers it in the channel-grouped order that a lane-parallel datapath consumes. The source tensor sits in memory in plain order: height, width, channel for activations, and output channel, input channel, kernel row, kernel column for weights. The walker does the reordering purely by address generation, so no data is moved or buffered inside the block. Channels are grouped in blocks of `LANES`, which is 8 by default, and those groups form the innermost dimensions of the walk.

A walk begins with a one-cycle `start_i` pulse. The pulse samples the mode and the shape inputs. In activation mode, `rows_i`, `cols_i` and `in_ch_i` give the tensor height, width and channel count. In weight mode, `rows_i` and `cols_i` give the kernel height and width, `in_ch_i` gives the input channels and `out_ch_i` gives the output channels. Offsets leave the block over a valid/ready handshake, and the final offset carries a last flag. One offset is issued per accepted beat, with no bubbles between beats.

Top module: `chgrp_addr_gen`

## Requirements
- R1: With `mode_i`=0 (activation), the walk nests, from outermost to innermost: row y, channel group g, column x, lane k. Each offset is (y*W + x)*C + g*LANES + k. The lanes of one pixel are therefore consecutive, every column of a row is visited for one group before the next group starts, and every group of a row is visited before the next row.
- R2: With `mode_i`=1 (weight), the walk nests, from outermost to innermost: output group og, input group ig, kernel row ky, kernel column kx, input lane a, output lane b. Each offset is ((o*I + i)*KH + ky)*KW + kx, where o = og*LANES + b and i = ig*LANES + a.
- R3: A start accepted while idle raises `addr_valid_o` on the next cycle, with offset 0. Each accepted beat advances the walk by exactly one position, and `addr_valid_o` stays high until the whole walk has been accepted.
- R4: `addr_last_o` is high only on the final offset of a walk. After that beat is accepted, `addr_valid_o` drops on the next cycle.
- R5: While `addr_valid_o` is high and `addr_ready_i` is low, `addr_o` and `addr_last_o` hold their values.
- R6: A start pulse during a walk is ignored. Changes on the mode and shape inputs after the start also have no effect on the offsets of the walk in progress.
- R7: A start with a channel count that is not a multiple of LANES, or with any dimension that is zero, sets `err_o` on the next cycle and produces no offsets. The next start with a legal shape clears `err_o`.
- R8: After reset, `addr_valid_o`, `addr_last_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Walk start pulse, sampled only while idle |
| mode_i | input | 1 | 0 activation, 1 weight |
| rows_i | input | DIM_W | Tensor height or kernel height |
| cols_i | input | DIM_W | Tensor width or kernel width |
| in_ch_i | input | DIM_W | Channel count (input channels in weight mode) |
| out_ch_i | input | DIM_W | Output channel count, weight mode only |
| addr_valid_o | output | 1 | Offset valid |
| addr_ready_i | input | 1 | Consumer accepts the offset |
| addr_o | output | ADDR_W | Element offset into the plain-order tensor |
| addr_last_o | output | 1 | Final offset of the walk |
| err_o | output | 1 | Last start carried an illegal shape |

## Verification
The bench uses the default parameters: DIM_W=8, ADDR_W=24 and LANES=8. With these values, the legality check tests the three low channel bits, and every offset of a 16-channel 8x8 activation tensor and of a 16x16x3x3 weight tensor fits in the address width. Full sequences are compared against nested-loop models of the stated orders, both with a consumer that is always ready and with periodic back-pressure. Degenerate shapes are also covered: a single pixel, a single group, and 1x1 kernels. The bench also drives a start pulse and changed shape inputs in the middle of a walk.

// File: rtl/chgrp_pkg.sv
package chgrp_pkg;
  typedef enum logic {
    MODE_ACT = 1'b0,
    MODE_WGT = 1'b1
  } walk_mode_e;

  // nesting levels, outermost first
  localparam int NUM_LVL = 6;
endpackage

// File: rtl/chgrp_lvl_cnt.sv
module chgrp_lvl_cnt #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [CW-1:0] lim_i,
  output logic [CW-1:0] val_o,
  output logic          wrap_o
);
  logic [CW-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (clr_i)  val_q <= '0;
    else if (inc_i)  val_q <= wrap_o ? '0 : val_q + 1'b1;
  end

  assign wrap_o = (val_q == lim_i);
  assign val_o  = val_q;

  // counter never runs past its level limit (R1, R2)
  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> val_q <= lim_i);
endmodule

// File: rtl/chgrp_addr_calc.sv
module chgrp_addr_calc
  import chgrp_pkg::*;
#(
  parameter int DIM_W  = 8,
  parameter int ADDR_W = 24,
  parameter int LANES  = 8
) (
  input  walk_mode_e                     mode_i,
  input  logic [NUM_LVL-1:0][DIM_W-1:0]  cnt_i,
  input  logic [DIM_W-1:0]               rows_i,
  input  logic [DIM_W-1:0]               cols_i,
  input  logic [DIM_W-1:0]               in_ch_i,
  output logic [ADDR_W-1:0]              addr_o
);
  localparam logic [ADDR_W-1:0] LN = ADDR_W'(LANES);

  logic [ADDR_W-1:0] c0, c1, c2, c3, c4, c5;
  logic [ADDR_W-1:0] rows_w, cols_w, ich_w;
  logic [ADDR_W-1:0] act_addr, wgt_addr, o_ch, i_ch;

  assign c0 = ADDR_W'(cnt_i[0]);
  assign c1 = ADDR_W'(cnt_i[1]);
  assign c2 = ADDR_W'(cnt_i[2]);
  assign c3 = ADDR_W'(cnt_i[3]);
  assign c4 = ADDR_W'(cnt_i[4]);
  assign c5 = ADDR_W'(cnt_i[5]);
  assign rows_w = ADDR_W'(rows_i);
  assign cols_w = ADDR_W'(cols_i);
  assign ich_w  = ADDR_W'(in_ch_i);

  // activation: levels y, group, x, lane
  assign act_addr = (c0 * cols_w + c2) * ich_w + c1 * LN + c3;

  // weight: levels og, ig, ky, kx, in lane, out lane
  assign o_ch     = c0 * LN + c5;
  assign i_ch     = c1 * LN + c4;
  assign wgt_addr = ((o_ch * ich_w + i_ch) * rows_w + c2) * cols_w + c3;

  assign addr_o = (mode_i == MODE_WGT) ? wgt_addr : act_addr;
endmodule

// File: rtl/chgrp_addr_gen.sv
module chgrp_addr_gen
  import chgrp_pkg::*;
#(
  parameter int DIM_W  = 8,
  parameter int ADDR_W = 24,
  parameter int LANES  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [DIM_W-1:0]  rows_i,
  input  logic [DIM_W-1:0]  cols_i,
  input  logic [DIM_W-1:0]  in_ch_i,
  input  logic [DIM_W-1:0]  out_ch_i,
  output logic              addr_valid_o,
  input  logic              addr_ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_last_o,
  output logic              err_o
);
  localparam int LG = $clog2(LANES);
  localparam logic [DIM_W-1:0] LANE_MAX = DIM_W'(LANES - 1);

  logic             busy_q, err_q;
  walk_mode_e       mode_q;
  logic [DIM_W-1:0] rows_q, cols_q, ich_q;
  logic [NUM_LVL-1:0][DIM_W-1:0] lim_q, lim_d, cnt_w;
  logic [NUM_LVL-1:0] inc_w, wrap_w;
  logic launch, step, all_wrap, cfg_ok, wgt_sel;

  assign wgt_sel = mode_i;
  assign launch  = start_i && !busy_q;
  assign step    = busy_q && addr_ready_i;

  always_comb begin
    cfg_ok = (rows_i != '0) && (cols_i != '0) && (in_ch_i != '0)
             && (in_ch_i[LG-1:0] == '0);
    if (wgt_sel) cfg_ok = cfg_ok && (out_ch_i != '0) && (out_ch_i[LG-1:0] == '0);
  end

  // per-level limit (count-1), outermost first
  always_comb begin
    if (wgt_sel) begin
      lim_d[0] = (out_ch_i >> LG) - 1'b1;
      lim_d[1] = (in_ch_i >> LG) - 1'b1;
      lim_d[2] = rows_i - 1'b1;
      lim_d[3] = cols_i - 1'b1;
      lim_d[4] = LANE_MAX;
      lim_d[5] = LANE_MAX;
    end else begin
      lim_d[0] = rows_i - 1'b1;
      lim_d[1] = (in_ch_i >> LG) - 1'b1;
      lim_d[2] = cols_i - 1'b1;
      lim_d[3] = LANE_MAX;
      lim_d[4] = '0;
      lim_d[5] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      mode_q <= MODE_ACT;
      rows_q <= '0;
      cols_q <= '0;
      ich_q  <= '0;
      lim_q  <= '0;
    end else if (launch) begin
      busy_q <= cfg_ok;
      err_q  <= !cfg_ok;
      mode_q <= walk_mode_e'(mode_i);
      rows_q <= rows_i;
      cols_q <= cols_i;
      ich_q  <= in_ch_i;
      lim_q  <= lim_d;
    end else if (step && all_wrap) begin
      busy_q <= 1'b0;
    end
  end

  // carry ripples from innermost level outward
  always_comb begin
    inc_w[NUM_LVL-1] = step;
    for (int k = NUM_LVL - 2; k >= 0; k--) inc_w[k] = inc_w[k+1] && wrap_w[k+1];
  end
  assign all_wrap = &wrap_w;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    chgrp_lvl_cnt #(.CW(DIM_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (launch),
      .inc_i  (inc_w[g]),
      .lim_i  (lim_q[g]),
      .val_o  (cnt_w[g]),
      .wrap_o (wrap_w[g])
    );
  end

  chgrp_addr_calc #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_calc (
    .mode_i  (mode_q),
    .cnt_i   (cnt_w),
    .rows_i  (rows_q),
    .cols_i  (cols_q),
    .in_ch_i (ich_q),
    .addr_o  (addr_o)
  );

  assign addr_valid_o = busy_q;
  assign addr_last_o  = busy_q && all_wrap;
  assign err_o        = err_q;

  assert_first_addr_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_valid_o) |-> addr_o == '0);
  assert_last_ends_walk_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && addr_ready_i && addr_last_o |=> !addr_valid_o);
  assert_hold_on_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && !addr_ready_i |=> addr_valid_o && $stable(addr_o) && $stable(addr_last_o));
  assert_start_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && start_i |=> $stable(mode_q) && $stable(rows_q) && $stable(cols_q) && $stable(ich_q));
  assert_err_no_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !addr_valid_o);
endmodule

// File: tb/chgrp_addr_gen_test.sv
module chgrp_addr_gen_test;
  localparam int DIM_W = 8, ADDR_W = 24, LANES = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0, ready = 1'b0;
  logic [DIM_W-1:0] rows = '0, cols = '0, ich = '0, och = '0;
  logic valid, last, err;
  logic [ADDR_W-1:0] addr;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  chgrp_addr_gen #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .LANES(LANES)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .rows_i(rows), .cols_i(cols), .in_ch_i(ich), .out_ch_i(och),
    .addr_valid_o(valid), .addr_ready_i(ready), .addr_o(addr),
    .addr_last_o(last), .err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic build_act(input int h, input int w, input int c);
    exp_q.delete();
    for (int y = 0; y < h; y++)
      for (int g = 0; g < c / LANES; g++)
        for (int x = 0; x < w; x++)
          for (int k = 0; k < LANES; k++)
            exp_q.push_back((y * w + x) * c + g * LANES + k);
  endtask

  task automatic build_wgt(input int o, input int i, input int kh, input int kw);
    exp_q.delete();
    for (int og = 0; og < o / LANES; og++)
      for (int ig = 0; ig < i / LANES; ig++)
        for (int ky = 0; ky < kh; ky++)
          for (int kx = 0; kx < kw; kx++)
            for (int a = 0; a < LANES; a++)
              for (int b = 0; b < LANES; b++)
                exp_q.push_back((((og * LANES + b) * i + ig * LANES + a) * kh + ky) * kw + kx);
  endtask

  task automatic launch(input logic m, input int r, input int c, input int ic, input int oc);
    @(negedge clk);
    mode = m; rows = 8'(r); cols = 8'(c); ich = 8'(ic); och = 8'(oc);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  // consume the whole walk and compare with exp_q
  task automatic run_walk(input string req, input bit stall, input bit disturb);
    int n = exp_q.size();
    int idx = 0, cyc = 0;
    bit held = 0;
    int held_addr = 0, held_last = 0;
    while (idx < n && cyc < 4 * n + 20) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) chk("R7 err cleared", int'(err), 0);
      if (held) begin
        chk("R5 addr hold", int'(addr), held_addr);
        chk("R5 last hold", int'(last), held_last);
      end
      if (disturb && cyc == 4) begin
        start = 1'b1; mode = ~mode; rows = 8'd5; cols = 8'd7; ich = 8'd32; och = 8'd8;
      end else begin
        start = 1'b0;
      end
      ready = !stall || (cyc % 3 != 2);
      if (!valid) begin
        chk({req, " valid during walk"}, 0, 1);
        break;
      end
      if (ready) begin
        chk({req, " addr"}, int'(addr), exp_q[idx]);
        chk("R4 last flag", int'(last), (idx == n - 1) ? 1 : 0);
        idx++;
        held = 0;
      end else begin
        held = 1; held_addr = int'(addr); held_last = int'(last);
      end
    end
    @(negedge clk);
    ready = 1'b0; start = 1'b0;
    chk("R3 beat count", idx, n);
    chk("R4 valid drops after last", int'(valid), 0);
  endtask

  task automatic t_reset();
    chk("R8 valid at reset", int'(valid), 0);
    chk("R8 last at reset", int'(last), 0);
    chk("R8 err at reset", int'(err), 0);
  endtask

  task automatic t_act_8x8x16(input bit stall);
    build_act(8, 8, 16);
    launch(1'b0, 8, 8, 16, 0);
    run_walk("R1 act 8x8x16", stall, 0);
  endtask

  task automatic t_act_small();
    build_act(2, 3, 8);
    launch(1'b0, 2, 3, 8, 0);
    run_walk("R1 act 2x3x8", 1, 0);
    build_act(1, 1, 24);
    launch(1'b0, 1, 1, 24, 0);
    run_walk("R1 act 1x1x24", 0, 0);
  endtask

  task automatic t_wgt(input bit stall);
    build_wgt(16, 16, 3, 3);
    launch(1'b1, 3, 3, 16, 16);
    run_walk("R2 wgt 16x16x3x3", stall, 0);
    build_wgt(8, 16, 1, 1);
    launch(1'b1, 1, 1, 16, 8);
    run_walk("R2 wgt 8x16x1x1", 0, 0);
  endtask

  task automatic t_busy_start();
    build_act(2, 4, 16);
    launch(1'b0, 2, 4, 16, 0);
    run_walk("R6 start while busy", 1, 1);
  endtask

  task automatic t_bad_cfg();
    launch(1'b0, 4, 4, 12, 0);
    @(negedge clk);
    chk("R7 err on chan 12", int'(err), 1);
    chk("R7 no valid on chan 12", int'(valid), 0);
    repeat (3) @(negedge clk);
    chk("R7 still no valid", int'(valid), 0);
    launch(1'b1, 3, 3, 16, 0);
    @(negedge clk);
    chk("R7 err on zero out ch", int'(err), 1);
    chk("R7 no valid on zero out ch", int'(valid), 0);
    launch(1'b0, 0, 4, 8, 0);
    @(negedge clk);
    chk("R7 err on zero rows", int'(err), 1);
    chk("R7 no valid on zero rows", int'(valid), 0);
    build_act(1, 2, 8);
    launch(1'b0, 1, 2, 8, 0);
    run_walk("R7 recovery walk", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_act_8x8x16(0);
    t_act_8x8x16(1);
    t_act_small();
    t_wgt(0);
    t_wgt(1);
    t_busy_start();
    t_bad_cfg();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule